// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns bus-cycle requests from a processor core into pin-level timing for an 8-bit bus with a 16-bit address. The lower address byte and the data byte take turns on one shared bus. The first T-state of each cycle puts the lower address byte on the shared bus and raises the address latch strobe, so that external latches can capture it. The later T-states use the same lines for data. The upper address byte has its own lines. A request names the cycle kind, the address and the write byte. The block then walks the T-states for that kind and drives the strobes and status lines. It stretches the transfer while the ready input is low.

An external master can take the bus with a hold request. The sequencer only lets go of the bus between machine cycles. It answers with hold acknowledge and switches off its address, data and control drivers. After the last T-state of a cycle, the block can accept the next request at once. Each cycle ends with a one-clock done pulse, which carries any byte that was read. Tri-state behaviour is given as output-enable ports: `addr_oe` covers the upper address and the control lines, and `ad_oe` covers the shared bus. Reset is asynchronous and active low. The system is expected to deassert it in step with the clock.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are: `ale`=0, `rd_n`=`wr_n`=`inta_n`=1, `addr_oe`=`ad_oe`=0, `hlda`=0, `done`=0, status `{s1,s0}`=00.
- R2: A request is accepted at an edge where `req_valid` and `req_ready` are both high. The next clock is T1.
  - In T1, `ale` is 1 for exactly that one clock. `ad_out` carries `addr[7:0]` with `ad_oe`=1.
  - For memory cycles, `addr_hi` carries `addr[15:8]`.
  - The kind codes on `req_kind` are: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge.
  - During the whole cycle, `{s1,s0}` is 11 for fetch, 10 for reads and 01 for writes. `io_m` is 1 for I/O and acknowledge cycles and 0 for memory cycles.
- R3: For fetch and read cycles, `rd_n` is low in T2, in any wait states and in T3, and `ad_oe` is 0 after T1. The shared bus value present at the end of T3 is returned on `rdata`, with `done`=1 for the single clock after T3.
- R4: For write cycles, `wr_n` is low in T2, in any wait states and in T3. `ad_out` holds the write byte with `ad_oe`=1 through the end of T3. `done` pulses for one clock after T3.
- R5: Timing of opcode fetch cycles:
  - A fetch lasts 4 T-states, or 6 T-states when `req_long` was set with the request.
  - In T4 to T6, no strobe is active and `ad_oe`=0.
  - Memory and I/O cycles last 3 T-states.
- R6: An interrupt acknowledge cycle drives `io_m`=1 and `{s1,s0}`=11. It pulses `inta_n` low with read timing, and `rd_n` stays high.
- R7: In I/O read and write cycles, `addr_hi` repeats the port byte `addr[7:0]`.
- R8: If `ready_in` is low at the end of T2 or of a wait state, another wait state follows, and the active strobe stays low. T3 follows the first such edge where `ready_in` is high.
- R9: Handling of a hold request:
  - `hold_req` is acted on only when idle or at the last T-state of a cycle. From the next clock, `hlda`=1 and `addr_oe`=`ad_oe`=0, while `ale` stays driven low.
  - Hold takes priority over a pending request.
  - One clock after `hold_req` falls, `hlda` returns to 0.
- R10: At most one of `rd_n`, `wr_n` and `inta_n` is low in any clock.
- R11: When no cycle is in progress, `{s1,s0}`=00 and `addr_oe`=0.
- R12: `req_ready` is 1 exactly when `hold_req` is low and the sequencer is either idle or in the last T-state of a cycle. This allows back-to-back cycles with no idle clock between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a cycle request |
| req_kind | input | 3 | Cycle kind code (see R2) |
| req_addr | input | 16 | Memory address, or I/O port in bits 7:0 |
| req_wdata | input | 8 | Byte to write |
| req_long | input | 1 | Stretch a fetch to 6 T-states |
| req_ready | output | 1 | Request can be taken at this edge |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 8 | Byte captured at the end of T3 |
| ready_in | input | 1 | Slow-device ready, low inserts wait states |
| hold_req | input | 1 | Another master wants the bus |
| hlda | output | 1 | Bus released to the other master |
| addr_hi | output | 8 | Upper address byte |
| addr_oe | output | 1 | Drive enable for upper address and control lines |
| ad_out | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus drive enable |
| ad_in | input | 8 | Shared bus input value |
| ale | output | 1 | Address latch strobe, never floated |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| io_m | output | 1 | 1 for I/O space, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |

## Verification
The bench builds the block with its default widths: a 16-bit address over an 8-bit shared bus. With equal byte widths, the port byte repeated on the upper lines in I/O cycles (R7) can be checked bit for bit. It also lets a pseudo-random shared-bus input show whether capture happens at the end of T3 and not one clock early or late. With these widths, every cycle kind, wait-state runs of random length, stretched fetches and hold requests that land in every T-state can all be reached in a short run. Back-to-back requests exercise the handoff from the last T-state to the next T1.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4,
    K_INTA  = 3'd5
  } cyc_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_T4, ST_T5, ST_T6, ST_HOLD
  } tstate_e;

  function automatic logic kind_is_write(input logic [2:0] k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic kind_is_io(input logic [2:0] k);
    return (k == K_IORD) || (k == K_IOWR) || (k == K_INTA);
  endfunction

  function automatic logic kind_is_read(input logic [2:0] k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic kind_has_status1(input logic [2:0] k);
    return !kind_is_write(k);
  endfunction

  function automatic logic kind_has_status0(input logic [2:0] k);
    return (k == K_FETCH) || (k == K_INTA) || kind_is_write(k);
  endfunction

endpackage

// File: rtl/busseq_fsm.sv
module busseq_fsm
  import busseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    ready_in,
  input  logic    hold_req,
  input  logic    is_fetch,
  input  logic    long_fetch,
  output tstate_e state,
  output logic    accept,
  output logic    at_boundary
);

  tstate_e state_nx;
  logic    last_t;

  always_comb begin
    last_t = ((state == ST_T3) && !is_fetch) ||
             ((state == ST_T4) && !long_fetch) ||
             (state == ST_T6);
    at_boundary = (state == ST_IDLE) || last_t;
    accept      = at_boundary && !hold_req && start;
  end

  always_comb begin
    state_nx = state;
    if (at_boundary) begin
      if (hold_req)   state_nx = ST_HOLD;
      else if (start) state_nx = ST_T1;
      else            state_nx = ST_IDLE;
    end else begin
      unique case (state)
        ST_T1:   state_nx = ST_T2;
        ST_T2:   state_nx = ready_in ? ST_T3 : ST_TW;
        ST_TW:   state_nx = ready_in ? ST_T3 : ST_TW;
        ST_T3:   state_nx = ST_T4;
        ST_T4:   state_nx = ST_T5;
        ST_T5:   state_nx = ST_T6;
        ST_HOLD: state_nx = hold_req ? ST_HOLD : ST_IDLE;
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // R8
  wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_T2 || state == ST_TW) && !ready_in) |=> (state == ST_TW));

  // R9
  hold_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T1 || state == ST_T2 || state == ST_TW) |=> (state != ST_HOLD));

  // R5
  fetch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T4 && !long_fetch) |=> (state == ST_IDLE || state == ST_T1 || state == ST_HOLD));

endmodule

// File: rtl/busseq_outdec.sv
module busseq_outdec
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  tstate_e           state,
  input  logic [2:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inta_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  output logic              hlda
);

  logic busy, strobe_ph;

  always_comb begin
    busy      = (state != ST_IDLE) && (state != ST_HOLD);
    strobe_ph = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
    hlda      = (state == ST_HOLD);
    addr_oe   = busy;
    ale       = (state == ST_T1);
    ad_oe     = (state == ST_T1) || (strobe_ph && kind_is_write(kind));
    ad_out    = (state == ST_T1) ? addr[DATA_W-1:0] : wdata;
    addr_hi   = kind_is_io(kind) ? HI_W'(addr[DATA_W-1:0]) : addr[ADDR_W-1:DATA_W];
    rd_n      = !(strobe_ph && kind_is_read(kind));
    wr_n      = !(strobe_ph && kind_is_write(kind));
    inta_n    = !(strobe_ph && (kind == K_INTA));
    io_m      = busy && kind_is_io(kind);
    s1        = busy && kind_has_status1(kind);
    s0        = busy && kind_has_status0(kind);
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_long,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic              ready_in,
  input  logic              hold_req,
  output logic              hlda,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inta_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0
);

  tstate_e           state;
  logic              accept, at_boundary;
  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              long_q;
  logic              done_nx;
  logic [DATA_W-1:0] rdata_nx;

  busseq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (req_valid),
    .ready_in    (ready_in),
    .hold_req    (hold_req),
    .is_fetch    (kind_q == K_FETCH),
    .long_fetch  (long_q),
    .state       (state),
    .accept      (accept),
    .at_boundary (at_boundary)
  );

  busseq_outdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .state   (state),
    .kind    (kind_q),
    .addr    (addr_q),
    .wdata   (wdata_q),
    .addr_hi (addr_hi),
    .addr_oe (addr_oe),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .inta_n  (inta_n),
    .io_m    (io_m),
    .s1      (s1),
    .s0      (s0),
    .hlda    (hlda)
  );

  assign req_ready = at_boundary && !hold_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= 3'd0;
      addr_q  <= '0;
      wdata_q <= '0;
      long_q  <= 1'b0;
    end else if (accept) begin
      kind_q  <= req_kind;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      long_q  <= req_long && (req_kind == K_FETCH);
    end
  end

  always_comb begin
    done_nx  = (state == ST_T3);
    rdata_nx = rdata;
    if ((state == ST_T3) && kind_is_read(kind_q)) rdata_nx = ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done  <= done_nx;
      rdata <= rdata_nx;
    end
  end

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);

  // R9
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!addr_oe && !ad_oe && !ale));

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_oe |-> (!s1 && !s0 && rd_n && wr_n && inta_n));

endmodule

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_kind;
  logic [15:0] req_addr;
  logic [7:0] req_wdata;
  logic       req_long;
  logic       req_ready, done, hlda, addr_oe, ad_oe, ale, rd_n, wr_n, inta_n, io_m, s1, s0;
  logic [7:0] rdata, addr_hi, ad_out, ad_in;
  logic       ready_in, hold_req;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  bit force_stall = 0;
  bit rand_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_long(req_long),
    .req_ready(req_ready), .done(done), .rdata(rdata), .ready_in(ready_in),
    .hold_req(hold_req), .hlda(hlda), .addr_hi(addr_hi), .addr_oe(addr_oe),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .inta_n(inta_n), .io_m(io_m), .s1(s1), .s0(s0)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // ready and shared-bus input generator
  always @(negedge clk) begin
    lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ad_in   = lfsr[7:0] ^ lfsr[15:8];
    ready_in = !force_stall && (!rand_ready || (lfsr[1:0] != 2'b00));
  end

  // behavioural reference model: m_t is T-state number, 0 when not in a cycle
  int  m_t = 0;
  bit  m_hold = 0, m_wait = 0, m_done = 0, m_long = 0;
  int  m_kind = 0;
  logic [15:0] m_addr = 0;
  logic [7:0]  m_wd = 0, m_rdata = 0;

  function automatic bit k_write(input int k); return k == 2 || k == 4; endfunction
  function automatic bit k_io(input int k);    return k == 3 || k == 4 || k == 5; endfunction
  function automatic bit k_read(input int k);  return k == 0 || k == 1 || k == 3; endfunction

  function automatic bit m_last();
    return (m_t == 3 && m_kind != 0) || (m_t == 4 && !m_long) || (m_t == 6);
  endfunction

  always @(posedge clk) begin
    bit take;
    cyc++;
    if (!rst_n) begin
      m_t = 0; m_hold = 0; m_wait = 0; m_done = 0; m_long = 0;
      m_kind = 0; m_addr = 0; m_wd = 0; m_rdata = 0;
    end else begin
      take = (m_t == 0 && !m_hold) || m_last();
      m_done = 0;
      case (m_t)
        1: m_t = 2;
        2: begin m_wait = !ready_in; if (ready_in) m_t = 3; end
        3: begin
             m_done = 1;
             if (k_read(m_kind)) m_rdata = ad_in;
             if (m_kind == 0) m_t = 4;
           end
        4: m_t = 5;
        5: m_t = 6;
        default: ;
      endcase
      if (m_hold) begin
        if (!hold_req) m_hold = 0;
      end else if (take) begin
        if (hold_req) begin m_hold = 1; m_t = 0; end
        else if (req_valid) begin
          m_t = 1; m_kind = int'(req_kind); m_addr = req_addr; m_wd = req_wdata;
          m_long = req_long && (req_kind == 3'd0);
        end else m_t = 0;
      end
    end
  end

  // compare every clock, late in the low phase
  always @(negedge clk) begin
    #4;
    if (rst_n && !finished) begin
      logic [1:0] st_e;
      bit sp;
      sp = (m_t == 2 || m_t == 3);
      chk("R2 ale", ale, m_t == 1);
      chk("R9 addr_oe", addr_oe, m_t != 0);
      chk("R9 hlda", hlda, m_hold);
      chk((m_kind == 0 && m_t >= 4) ? "R5 ad_oe" : "R4 ad_oe", ad_oe,
          (m_t == 1) || (sp && k_write(m_kind)));
      if (m_t == 1) chk("R2 ad_out", ad_out, m_addr[7:0]);
      if (sp && k_write(m_kind)) chk("R4 ad_out", ad_out, m_wd);
      if (m_t >= 1 && m_t <= 3)
        chk(k_io(m_kind) ? "R7 addr_hi" : "R2 addr_hi", addr_hi,
            k_io(m_kind) ? m_addr[7:0] : m_addr[15:8]);
      chk(m_wait ? "R8 rd_n" : "R3 rd_n", rd_n, !(sp && k_read(m_kind)));
      chk(m_wait ? "R8 wr_n" : "R4 wr_n", wr_n, !(sp && k_write(m_kind)));
      chk("R6 inta_n", inta_n, !(sp && m_kind == 5));
      chk("R10 strobes", ($countones({~rd_n, ~wr_n, ~inta_n}) <= 1), 1);
      if (m_t != 0) begin
        st_e = (m_kind == 0 || m_kind == 5) ? 2'b11 : k_write(m_kind) ? 2'b01 : 2'b10;
        chk(m_kind == 5 ? "R6 status" : "R2 status", {s1, s0}, st_e);
        chk(m_kind == 5 ? "R6 io_m" : "R2 io_m", io_m, k_io(m_kind));
      end else chk("R11 idle status", {s1, s0, addr_oe}, 3'b000);
      chk("R3 done", done, m_done);
      if (m_done) chk("R3 rdata", rdata, m_rdata);
      chk("R12 req_ready", req_ready, ((m_t == 0 && !m_hold) || m_last()) && !hold_req);
    end
  end

  task automatic issue(input logic [2:0] k, input logic [15:0] a, input logic [7:0] w, input logic lg);
    req_valid = 1; req_kind = k; req_addr = a; req_wdata = w; req_long = lg;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_kind = 0; req_addr = 0; req_wdata = 0;
    req_long = 0; hold_req = 0;
    idle(3);
    // R1 reset values
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {rd_n, wr_n, inta_n}, 3'b111);
    chk("R1 oe", {addr_oe, ad_oe, hlda, done}, 4'b0000);
    chk("R1 status", {s1, s0}, 2'b00);
    rst_n = 1;
    idle(2);
    // each kind, separated
    issue(3'd0, 16'h5000, 8'h00, 0); idle(6);
    issue(3'd1, 16'h1234, 8'h00, 0); idle(4);
    issue(3'd2, 16'hBEEF, 8'h5A, 0); idle(4);
    issue(3'd3, 16'h77C3, 8'h00, 0); idle(4);
    issue(3'd4, 16'h9911, 8'hA5, 0); idle(4);
    issue(3'd5, 16'h0000, 8'h00, 0); idle(4);
    issue(3'd0, 16'h2001, 8'h00, 1); idle(8);
    // back-to-back
    issue(3'd0, 16'h3000, 8'h00, 0);
    issue(3'd1, 16'h3001, 8'h00, 0);
    issue(3'd2, 16'h4000, 8'h3C, 0);
    issue(3'd0, 16'h3002, 8'h00, 1);
    issue(3'd4, 16'h0042, 8'h81, 0);
    idle(8);
    // R8 forced wait states
    force_stall = 1;
    issue(3'd1, 16'hC0DE, 8'h00, 0);
    idle(4);
    force_stall = 0;
    idle(4);
    force_stall = 1;
    issue(3'd2, 16'hC0DF, 8'h11, 0);
    idle(3);
    force_stall = 0;
    idle(4);
    // R9 hold while idle, and hold raised in mid-cycle
    hold_req = 1; idle(5); hold_req = 0; idle(2);
    req_valid = 1; req_kind = 3'd1; req_addr = 16'h6666; req_long = 0;
    @(negedge clk); req_valid = 0;
    hold_req = 1; idle(6); hold_req = 0; idle(3);
    // R9 hold beats a pending request
    hold_req = 1; req_valid = 1; req_kind = 3'd2; req_addr = 16'h7777; req_wdata = 8'h99;
    idle(3); hold_req = 0;
    #1; while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); req_valid = 0; idle(5);
    // random mix
    rand_ready = 1;
    for (int i = 0; i < 400; i++) begin
      logic [2:0] k;
      k = 3'($urandom % 6);
      issue(k, 16'($urandom), 8'($urandom), ($urandom % 3) == 0);
      if (($urandom % 5) == 0) idle(int'($urandom % 4));
      if (($urandom % 9) == 0) begin
        hold_req = 1; idle(1 + int'($urandom % 4)); hold_req = 0;
      end
    end
    rand_ready = 0;
    idle(10);
    finish_run();
  end

endmodule